// File: doc/BRIEF.md
# Page Write Buffer Controller

This block models the page-programming engine of a byte-wide non-volatile memory. It receives byte writes that upstream logic has already qualified. Each write carries an address and a data byte. The low address bits choose a byte slot inside a page, and the upper bits name the page. A burst of writes to one page fills a page buffer. Every accepted write restarts a load-window timer. When the window runs out with no new write, one internal programming cycle starts. That cycle has a fixed length and commits all loaded bytes to the storage array at once.

While programming runs, the block reports busy after a short delay and ignores new writes. A read of the most recently stored address returns the inverse of that byte's top bit as a polling status. All other reads return the array contents. An input flag carries the result of an external write-protection check. A write that fails the check still restarts the window and can open a burst, but its data is never stored. A write aimed at a different page during a burst is dropped and sets a sticky error flag.

Top module: `pgw_ctrl`

## Requirements
- R1: After reset, `busy` and `page_err` are 0, and every array location reads 8'hFF.
- R2: Each accepted write restarts the load window. Programming begins exactly WIN_CYC clock edges after the last accepted write. A write arriving WIN_CYC edges after the previous one still extends the burst.
- R3: The byte offset is `wr_addr[OFF_W-1:0]` and the page is `wr_addr[ADDR_W-1:OFF_W]`. All loaded bytes become visible in the array together, in the cycle in which `busy` falls.
- R4: During a burst, a write whose page differs from the burst's page is dropped, does not restart the window, and sets `page_err`. `page_err` stays 1 until reset.
- R5: Programming lasts PROG_CYC cycles whatever the number of bytes loaded (1 to 2**OFF_W).
- R6: `busy` rises BUSY_DLY cycles after programming starts and falls when programming ends. It is first seen WIN_CYC+BUSY_DLY edges after the last write and stays high for PROG_CYC-BUSY_DLY cycles.
- R7: While programming, a read of the last stored address returns {~d[7], 7'b0}, where d is that stored byte. Other addresses return their old array contents.
- R8: Writes presented while programming are ignored: no data is stored and no new burst is opened.
- R9: Offsets in the page that were not loaded keep their previous array contents.
- R10: A write with `wr_allow` low restarts the window and can open a burst, but its data is not stored. Such a write is also not used for polling.
- R11: When one offset is written more than once in a burst, the last value is committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Qualified byte-write strobe, one cycle per byte |
| wr_allow | input | 1 | Protection check passed; when low the data is discarded |
| wr_addr | input | ADDR_W | Write address (page and offset) |
| wr_data | input | 8 | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Array contents, or the polling byte during programming |
| busy | output | 1 | High while the programming cycle is in progress |
| page_err | output | 1 | Sticky flag: a write to a different page occurred during a burst |

## Verification
The hardest case to produce is a write that lands exactly on the last edge of the load window. It must win over the expiry, which would otherwise start programming on that same edge. The bench places a second write exactly WIN_CYC edges after the first. It then checks that `busy` rises a full window plus the busy delay after the later write. A mirror case uses a gap one edge longer, so the later write falls into programming and is shown to have no effect. The bench also samples polling reads in the short interval between the start of programming and the commit, and it checks every array address after each burst.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } pgw_state_e;

  // Status byte returned for the last stored address while programming.
  function automatic logic [7:0] poll_byte(input logic [7:0] d);
    return {~d[7], 7'b0};
  endfunction

endpackage

// File: rtl/pgw_timer.sv
module pgw_timer #(
  parameter int CNT_W    = 8,
  parameter int LOAD_VAL = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  output logic [CNT_W-1:0] cnt,
  output logic             fire
);

  assign fire = run && !start && (cnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (start)              cnt <= CNT_W'(LOAD_VAL);
    else if (run && cnt != '0)   cnt <= cnt - 1'b1;
  end

  // R5: a running count steps down by exactly one each cycle
  a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !start && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/pgw_buffer.sv
module pgw_buffer #(
  parameter int OFF_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [OFF_W-1:0]   off,
  input  logic [7:0]         data,
  input  logic               clr,
  output logic [8*(2**OFF_W)-1:0] flat,
  output logic [2**OFF_W-1:0]     mask
);

  localparam int SLOTS = 2**OFF_W;

  logic [7:0] slot_q [SLOTS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '0;
      for (int i = 0; i < SLOTS; i++) slot_q[i] <= 8'h00;
    end else if (clr) begin
      mask <= '0;
    end else if (wr) begin
      slot_q[off] <= data;
      mask[off]   <= 1'b1;
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_flat
    assign flat[g*8 +: 8] = slot_q[g];
  end

  // R3: the valid mask is empty after a commit
  a_r3_mask_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (mask == '0));

endmodule

// File: rtl/pgw_array.sv
module pgw_array #(
  parameter int ADDR_W = 10,
  parameter int OFF_W  = 7
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      commit,
  input  logic [ADDR_W-OFF_W-1:0]   page,
  input  logic [8*(2**OFF_W)-1:0]   flat,
  input  logic [2**OFF_W-1:0]       mask,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [7:0]                rd_q
);

  localparam int DEPTH = 2**ADDR_W;
  localparam int SLOTS = 2**OFF_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (commit) begin
      for (int i = 0; i < SLOTS; i++)
        if (mask[i]) mem[{page, OFF_W'(i)}] <= flat[i*8 +: 8];
    end
  end

  assign rd_q = mem[rd_addr];

endmodule

// File: rtl/pgw_ctrl.sv
module pgw_ctrl #(
  parameter int ADDR_W   = 10,
  parameter int OFF_W    = 7,
  parameter int WIN_CYC  = 3000,
  parameter int PROG_CYC = 600000,
  parameter int BUSY_DLY = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_allow,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              busy,
  output logic              page_err
);
  import pgw_pkg::*;

  localparam int PG_W  = ADDR_W - OFF_W;
  localparam int WIN_W = $clog2(WIN_CYC + 1);
  localparam int PRG_W = $clog2(PROG_CYC + 1);

  pgw_state_e        state;
  logic [PG_W-1:0]   cur_page;
  logic [ADDR_W-1:0] last_addr;
  logic [7:0]        last_data;
  logic              last_vld;

  // Named internal events
  logic page_match, wr_accept, wr_store, page_mismatch;
  logic win_expire, prog_done, poll_hit;
  logic [WIN_W-1:0] win_cnt;
  logic [PRG_W-1:0] prog_cnt;
  logic [8*(2**OFF_W)-1:0] buf_flat;
  logic [2**OFF_W-1:0]     buf_mask;
  logic [7:0]              arr_q;

  assign page_match    = (wr_addr[ADDR_W-1:OFF_W] == cur_page);
  assign wr_accept     = wr_en && ((state == ST_IDLE) || (state == ST_LOAD && page_match));
  assign page_mismatch = wr_en && (state == ST_LOAD) && !page_match;
  assign wr_store      = wr_accept && wr_allow;

  pgw_timer #(.CNT_W(WIN_W), .LOAD_VAL(WIN_CYC)) u_win (
    .clk(clk), .rst_n(rst_n), .start(wr_accept), .run(state == ST_LOAD),
    .cnt(win_cnt), .fire(win_expire));

  pgw_timer #(.CNT_W(PRG_W), .LOAD_VAL(PROG_CYC)) u_prog (
    .clk(clk), .rst_n(rst_n), .start(win_expire), .run(state == ST_PROG),
    .cnt(prog_cnt), .fire(prog_done));

  pgw_buffer #(.OFF_W(OFF_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr(wr_store), .off(wr_addr[OFF_W-1:0]),
    .data(wr_data), .clr(prog_done), .flat(buf_flat), .mask(buf_mask));

  pgw_array #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .commit(prog_done), .page(cur_page),
    .flat(buf_flat), .mask(buf_mask), .rd_addr(rd_addr), .rd_q(arr_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cur_page  <= '0;
      last_addr <= '0;
      last_data <= 8'h00;
      last_vld  <= 1'b0;
      page_err  <= 1'b0;
    end else begin
      if (page_mismatch) page_err <= 1'b1;
      if (wr_store) begin
        last_vld  <= 1'b1;
        last_addr <= wr_addr;
        last_data <= wr_data;
      end else if (state == ST_IDLE && wr_accept) begin
        last_vld  <= 1'b0;
      end
      unique case (state)
        ST_IDLE: if (wr_accept) begin
          state    <= ST_LOAD;
          cur_page <= wr_addr[ADDR_W-1:OFF_W];
        end
        ST_LOAD: if (win_expire) state <= ST_PROG;
        ST_PROG: if (prog_done)  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (state == ST_PROG) && (prog_cnt <= PRG_W'(PROG_CYC - BUSY_DLY));
  assign poll_hit = (state == ST_PROG) && last_vld && (rd_addr == last_addr);
  assign rd_data  = poll_hit ? poll_byte(last_data) : arr_q;

  // R2: an accepted write reloads the full window
  a_r2_window_reload: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> (win_cnt == WIN_W'(WIN_CYC)));
  // R8: nothing is accepted while programming
  a_r8_prog_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PROG) |-> !wr_accept);
  // R4: the burst page never changes during loading
  a_r4_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOAD && $past(state) == ST_LOAD) |-> (cur_page == $past(cur_page)));
  // R4: the error flag is sticky
  a_r4_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(page_err) |-> page_err);
  // R6: busy releases right after programming completes
  a_r6_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |=> !busy);

endmodule

// File: tb/sim_pgw_ctrl.sv
`timescale 1ns/1ps
module sim_pgw_ctrl;
  localparam int AW = 10;
  localparam int OW = 7;
  localparam int W  = 8;
  localparam int P  = 20;
  localparam int D  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_allow = 1'b1;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic busy, page_err;

  int checks = 0;
  int fails  = 0;
  logic [7:0] ref_mem [2**AW];

  pgw_ctrl #(.ADDR_W(AW), .OFF_W(OW), .WIN_CYC(W), .PROG_CYC(P), .BUSY_DLY(D)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_allow(wr_allow),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .busy(busy), .page_err(page_err));

  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int addr_of(input int pg, input int off);
    return pg * (2**OW) + off;
  endfunction

  function automatic logic [7:0] pat(input int off);
    return 8'((off * 37 + 5) & 255);
  endfunction

  // Called at a falling edge; the write is sampled at the next rising edge.
  task automatic wr(input int a, input logic [7:0] d, input logic ok);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d; wr_allow = ok;
    @(negedge clk);
    wr_en = 1'b0; wr_allow = 1'b1;
  endtask

  task automatic rd(input int a, output logic [7:0] q);
    rd_addr = AW'(a);
    #1 q = rd_data;
  endtask

  task automatic wait_rise(output int n);
    n = 0;
    while (!busy && n < 1000) begin @(negedge clk); n++; end
  endtask

  task automatic wait_fall(output int n);
    n = 0;
    while (busy && n < 1000) begin @(negedge clk); n++; end
  endtask

  task automatic sweep(input string req);
    logic [7:0] q;
    for (int a = 0; a < 2**AW; a++) begin
      rd(a, q);
      chk(req, q, ref_mem[a]);
    end
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n;
    logic [7:0] q;
    for (int a = 0; a < 2**AW; a++) ref_mem[a] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 busy", busy, 0);
    chk("R1 page_err", page_err, 0);
    sweep("R1 erased array");

    // R3/R5/R6/R7: full page burst on page 1
    for (int o = 0; o < 2**OW; o++) wr(addr_of(1, o), pat(o), 1'b1);
    wait_rise(n);
    chk("R2 R6 busy rise delay", n, W + D);
    rd(addr_of(1, 127), q);
    chk("R7 poll last addr", q, {~pat(127)[7], 7'b0});
    rd(addr_of(1, 0), q);
    chk("R7 other addr old data", q, 8'hFF);
    wait_fall(n);
    chk("R5 R6 busy length full page", n, P - D);
    for (int o = 0; o < 2**OW; o++) ref_mem[addr_of(1, o)] = pat(o);
    sweep("R3 full page commit");

    // R2 boundary gap, R11 rewrite, R9 unloaded slots kept
    wr(addr_of(1, 3), 8'hC3, 1'b1);
    repeat (W - 1) @(negedge clk);
    wr(addr_of(1, 5), 8'h11, 1'b1);
    wr(addr_of(1, 5), 8'hA5, 1'b1);
    wait_rise(n);
    chk("R2 window extended at boundary", n, W + D);
    rd(addr_of(1, 5), q);
    chk("R7 poll bit7 set", q, 8'h00);
    rd(addr_of(1, 3), q);
    chk("R7 old data during prog", q, pat(3));
    wait_fall(n);
    chk("R5 busy length two bytes", n, P - D);
    ref_mem[addr_of(1, 3)] = 8'hC3;
    ref_mem[addr_of(1, 5)] = 8'hA5;
    sweep("R9 R11 partial page");

    // R4: write to another page during burst
    wr(addr_of(3, 0), 8'h33, 1'b1);
    wr(addr_of(4, 0), 8'h44, 1'b1);
    chk("R4 page_err set", page_err, 1);
    wait_rise(n);
    chk("R4 mismatch no restart", n, W + D - 1);
    wait_fall(n);
    chk("R5 busy length one byte", n, P - D);
    ref_mem[addr_of(3, 0)] = 8'h33;
    sweep("R4 mismatch dropped");

    // R8: write during programming ignored; R2 gap of W+1 ends the burst
    wr(addr_of(5, 1), 8'h55, 1'b1);
    repeat (W) @(negedge clk);
    wr(addr_of(5, 2), 8'h66, 1'b1);
    wait_rise(n);
    chk("R2 R8 late write not extending", n, D - 1);
    wait_fall(n);
    chk("R5 busy length", n, P - D);
    repeat (W + D + 2) @(negedge clk);
    chk("R8 no burst opened", busy, 0);
    ref_mem[addr_of(5, 1)] = 8'h55;
    sweep("R8 prog write ignored");
    chk("R4 page_err sticky", page_err, 1);

    // R10: protected write
    wr(addr_of(6, 0), 8'h12, 1'b0);
    wait_rise(n);
    chk("R10 window started", n, W + D);
    rd(addr_of(6, 0), q);
    chk("R10 no polling", q, 8'hFF);
    wait_fall(n);
    chk("R10 R5 busy length", n, P - D);
    sweep("R10 data discarded");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule